// File: doc/BRIEF.md
# Daisy-Chainable Channel Configuration Shifter

This block is the serial programming port of an eight-channel beamforming mixer array. A host sends a bit stream on a serial data pin. Each rising edge of a dedicated serial clock moves one bit into a 40-bit shift chain. The chain holds five bits per channel: a 4-bit phase code and one channel enable bit. A serial output passes on the bits that leave the far end of the chain. Several devices can therefore sit on one bus, each feeding the next. The new data reaches the channel outputs only when an active-low load strobe is pulsed low and then released. On that release a holding register copies the chain. The holding register drives the per-channel phase codes and enable flags.

The three serial pins are asynchronous to the block clock. Each pin passes through a two-stage synchronizer. A small state machine then decodes the pin activity into one-cycle actions. It has three states:
- `ST_IDLE`: serial clock low and load high.
- `ST_SCLK_HI`: entered on a rising serial clock, which also shifts one bit in. The state returns to `ST_IDLE` on the falling serial clock, which also updates the serial output.
- `ST_LOAD_LO`: entered from `ST_IDLE` when load goes low, which takes priority over a serial clock edge. While the machine is in this state it counts block clocks. When load rises the machine returns to `ST_IDLE`, and the chain is captured only if the low time was long enough.

The serial clock runs at up to 10 MHz, so each of its phases lasts several block clocks.

Top module: `cfg_shifter`

## Requirements
- R1: After reset, every `ch_phase` nibble is 0, every `ch_enable` bit is 0, `ser_dout` is 0 and the shift chain holds all zeros.
- R2: Each frame of 40 bits is sent starting with channel 7 and ending with channel 0. Within a channel's five bits, the phase code comes first, MSB first, and the enable bit comes last. After a valid load, channel c shows its phase code on `ch_phase[4c+3:4c]` and its enable bit on `ch_enable[c]`.
- R3: `ser_dout` changes only after a falling edge of `ser_clk` and keeps its value while `ser_clk` is high. After the fall that follows the n-th shift, it shows the bit sent in shift n-39, or the reset zero of the chain when n < 40. The delay through one device is therefore 40 serial clocks.
- R4: Shifting with `ser_load_n` held high never changes `ch_phase` or `ch_enable`. A rising edge of `ser_load_n` after a valid low time copies the chain to these outputs.
- R5: A low pulse on `ser_load_n` lasting at most LOAD_MIN_CYC block clocks is discarded and leaves the outputs unchanged. A pulse lasting at least LOAD_MIN_CYC+1 block clocks is accepted.
- R6: While `ser_load_n` is low, edges on `ser_clk` shift nothing, so a capture at the end of that low pulse loads the chain contents that were present before the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_din | input | 1 | Serial data in |
| ser_load_n | input | 1 | Active-low load strobe; capture happens on its release |
| ser_dout | output | 1 | Serial data out to the next device |
| ch_phase | output | 32 | Phase code of each channel, 4 bits per channel, channel 0 in the low nibble |
| ch_enable | output | 8 | Enable flag of each channel, channel 0 in bit 0 |

## Verification
Each pin edge passes through two synchronizer flops. The state machine acts on the synchronized edge, and the register it drives updates on the next clock. A shift, a serial-output update or a capture is therefore due three block clocks after the pin edge. The bench holds every serial clock phase for five block clocks and waits six block clocks after releasing the load strobe before it samples. It drives and samples on falling clock edges, so every result has settled by the time it is read. The serial output is also sampled in the middle of each high phase of the serial clock, which shows that it has not yet moved.

// File: rtl/cfgsh_pkg.sv
package cfgsh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SCLK_HI = 2'd1,
        ST_LOAD_LO = 2'd2
    } port_state_t;
endpackage

// File: rtl/cfgsh_sync.sv
module cfgsh_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/cfgsh_fsm.sv
module cfgsh_fsm
    import cfgsh_pkg::*;
#(
    parameter int LOAD_MIN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic load_n_s,
    output logic shift_en,
    output logic sdo_upd,
    output logic capture
);
    localparam int CNT_W = $clog2(LOAD_MIN_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOAD_MIN_CYC);

    port_state_t     state, nxt;
    logic            sclk_d;
    logic [CNT_W-1:0] low_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            sclk_d <= 1'b0;
        end else begin
            state  <= nxt;
            sclk_d <= sclk_s;
        end
    end

    // load low-time counter, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (state != ST_LOAD_LO) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_MAX) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // transitions and one-cycle actions
    always_comb begin
        nxt      = state;
        shift_en = 1'b0;
        sdo_upd  = 1'b0;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!load_n_s) begin
                    nxt = ST_LOAD_LO;
                end else if (sclk_s && !sclk_d) begin
                    nxt      = ST_SCLK_HI;
                    shift_en = 1'b1;
                end
            end
            ST_SCLK_HI: begin
                if (!sclk_s) begin
                    nxt     = ST_IDLE;
                    sdo_upd = 1'b1;
                end
            end
            ST_LOAD_LO: begin
                if (load_n_s) begin
                    nxt     = ST_IDLE;
                    capture = (low_cnt == CNT_MAX);
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    p_shift_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> (sclk_s && !$past(sclk_s) && load_n_s));

    p_capture_on_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (load_n_s && !$past(load_n_s)));

    p_update_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_upd |-> (!sclk_s && $past(sclk_s)));
endmodule

// File: rtl/cfgsh_chain.sv
module cfgsh_chain #(
    parameter int LEN = 40
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           sdo_upd,
    input  logic           sdi,
    output logic [LEN-1:0] chain,
    output logic           sdo
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else if (shift_en) begin
            chain <= {chain[LEN-2:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo <= 1'b0;
        end else if (sdo_upd) begin
            sdo <= chain[LEN-1];
        end
    end

    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (chain[0] == $past(sdi)) && (chain[LEN-1:1] == $past(chain[LEN-2:0])));

    p_chain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(chain));

    p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_upd |=> $stable(sdo));

    p_sdo_far_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_upd |=> (sdo == $past(chain[LEN-1])));
endmodule

// File: rtl/cfgsh_hold.sv
module cfgsh_hold #(
    parameter int NUM_CH  = 8,
    parameter int PHASE_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      capture,
    input  logic [NUM_CH*(PHASE_W+1)-1:0] chain,
    output logic [NUM_CH*PHASE_W-1:0] ch_phase,
    output logic [NUM_CH-1:0]         ch_enable
);
    localparam int FIELD_W = PHASE_W + 1;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_phase[c*PHASE_W +: PHASE_W] <= '0;
                ch_enable[c]                   <= 1'b0;
            end else if (capture) begin
                ch_phase[c*PHASE_W +: PHASE_W] <= chain[c*FIELD_W+1 +: PHASE_W];
                ch_enable[c]                   <= chain[c*FIELD_W];
            end
        end

        p_field_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
            capture |=> (ch_phase[c*PHASE_W +: PHASE_W] == $past(chain[c*FIELD_W+1 +: PHASE_W]))
                        && (ch_enable[c] == $past(chain[c*FIELD_W])));
    end

    p_outputs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(ch_phase) && $stable(ch_enable)));
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
    parameter int NUM_CH       = 8,
    parameter int PHASE_W      = 4,
    parameter int LOAD_MIN_CYC = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ser_clk,
    input  logic                      ser_din,
    input  logic                      ser_load_n,
    output logic                      ser_dout,
    output logic [NUM_CH*PHASE_W-1:0] ch_phase,
    output logic [NUM_CH-1:0]         ch_enable
);
    localparam int CHAIN_LEN = NUM_CH * (PHASE_W + 1);

    logic [2:0]           pins_s;
    logic                 shift_en, sdo_upd, capture;
    logic [CHAIN_LEN-1:0] chain;

    // bit order {din, load_n, sclk}; idle levels 0,1,0
    cfgsh_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_din, ser_load_n, ser_clk}),
        .q     (pins_s)
    );

    cfgsh_fsm #(.LOAD_MIN_CYC(LOAD_MIN_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[0]),
        .load_n_s (pins_s[1]),
        .shift_en (shift_en),
        .sdo_upd  (sdo_upd),
        .capture  (capture)
    );

    cfgsh_chain #(.LEN(CHAIN_LEN)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .sdo_upd  (sdo_upd),
        .sdi      (pins_s[2]),
        .chain    (chain),
        .sdo      (ser_dout)
    );

    cfgsh_hold #(.NUM_CH(NUM_CH), .PHASE_W(PHASE_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .chain     (chain),
        .ch_phase  (ch_phase),
        .ch_enable (ch_enable)
    );

    p_shift_excl_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && capture));
endmodule

// File: tb/cfg_shifter_bench.sv
module cfg_shifter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        ser_load_n = 1'b1;
    logic        ser_dout;
    logic [31:0] ch_phase;
    logic [7:0]  ch_enable;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cfg_shifter u_cfg_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_din    (ser_din),
        .ser_load_n (ser_load_n),
        .ser_dout   (ser_dout),
        .ch_phase   (ch_phase),
        .ch_enable  (ch_enable)
    );

    // {phase[31:0], enable[7:0]}
    localparam logic [39:0] FRAMES [4] = '{
        {32'h7654_3210, 8'hFF},
        {32'hFEDC_BA98, 8'h5A},
        {32'hA5A5_A5A5, 8'h81},
        {32'h0F0F_0F0F, 8'h00}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) ser_din = b;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        repeat (5) @(negedge clk);
        ser_clk = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic send_frame(input logic [39:0] f);
        for (int c = 7; c >= 0; c--) begin
            for (int b = 3; b >= 0; b--) send_bit(f[8 + 4*c + b]);
            send_bit(f[c]);
        end
    endtask

    task automatic pulse_load(input int n);
        @(negedge clk) ser_load_n = 1'b0;
        repeat (n) @(negedge clk);
        ser_load_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [39:0] prev;
        logic [79:0] pat;
        logic        exp_sdo;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        chk("R1 phase", {32'h0, ch_phase}, 64'h0);
        chk("R1 enable", {56'h0, ch_enable}, 64'h0);
        chk("R1 dout", {63'h0, ser_dout}, 64'h0);

        // table walk: R4 no change before load, R2 mapping after load
        prev = 40'h0;
        for (int i = 0; i < 4; i++) begin
            send_frame(FRAMES[i]);
            chk("R4 shift-only keeps outputs", {24'h0, ch_phase, ch_enable}, {24'h0, prev});
            pulse_load(12);
            chk("R2 frame loaded", {24'h0, ch_phase, ch_enable}, {24'h0, FRAMES[i]});
            prev = FRAMES[i];
        end

        // R5: short load pulse discarded, long accepted
        send_frame(FRAMES[1]);
        pulse_load(2);
        chk("R5 short pulse ignored", {24'h0, ch_phase, ch_enable}, {24'h0, FRAMES[3]});
        pulse_load(12);
        chk("R5 long pulse accepted", {24'h0, ch_phase, ch_enable}, {24'h0, FRAMES[1]});

        // R6: serial clocks while load low shift nothing
        @(negedge clk) ser_load_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            ser_din = 1'b1;
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (5) @(negedge clk);
            ser_clk = 1'b0;
            repeat (5) @(negedge clk);
        end
        ser_load_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R6 clocks during load ignored", {24'h0, ch_phase, ch_enable}, {24'h0, FRAMES[1]});

        // R1 again from a non-zero state
        do_reset();
        chk("R1 phase after reset", {32'h0, ch_phase}, 64'h0);
        chk("R1 enable after reset", {56'h0, ch_enable}, 64'h0);

        // R3: daisy-chain output, 40-bit delay, moves only on fall
        pat = 80'hC3A5_1E96_F00F_5AA5_3C69;
        exp_sdo = 1'b0;
        for (int n = 0; n < 80; n++) begin
            @(negedge clk) ser_din = pat[n];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (5) @(negedge clk);
            chk("R3 dout steady while clock high", {63'h0, ser_dout}, {63'h0, exp_sdo});
            ser_clk = 1'b0;
            repeat (5) @(negedge clk);
            exp_sdo = (n >= 39) ? pat[n-39] : 1'b0;
            chk("R3 dout after fall", {63'h0, ser_dout}, {63'h0, exp_sdo});
        end
        chk("R4 outputs untouched by daisy traffic", {24'h0, ch_phase, ch_enable}, 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule